// File: doc/BRIEF.md
# Programmable Clock-Enable Divider with Selectable Divisor Encoding

This block turns a fast input clock into a periodic one-cycle enable pulse. Software writes a divide field through a 32-bit register port. A build-time parameter sets how that raw field becomes the integer divisor N. The options are field plus one, the field taken as is (one-based), or two raised to the field. The pulse output `tick_o` is high for exactly one input-clock cycle out of every N. Logic downstream uses it as a clock enable, so no new clock domain is created.

In the one-based encoding a zero field has two possible meanings. If `ALLOW_ZERO` is set, zero means bypass: the divisor is one. If it is not set, zero is invalid. In that case the pulse is held off and a flag reports the condition.

With `HIWORD_MASK` set, bits 31:16 of a write are per-bit write enables for the field held in bits 15:0. Several agents can then update parts of the field without a read-modify-write. A changed divisor is applied only when the current period ends. The register read-back and the decoded divisor are both visible at all times.

Top module: `clkdiv_enc`

## Requirements
- R1: With `ENC = ENC_PLUS_ONE`, the divisor is the field value plus one.
- R2: With `ENC = ENC_ONE_BASED`, a non-zero field value is used directly as the divisor.
- R3: With `ENC = ENC_ONE_BASED` and `ALLOW_ZERO = 0`, a zero field is invalid. Once it is loaded, `tick_o` stays low and `invalid_o` stays high until a valid divisor is loaded. While the loaded divisor is invalid, a new value is loaded on the clock edge after it is written. `div_o` reads 0 while the field is zero.
- R4: With `ENC = ENC_ONE_BASED` and `ALLOW_ZERO = 1`, a zero field gives divisor 1: `tick_o` is high every cycle and `invalid_o` stays low.
- R5: With `ENC = ENC_POW2`, the divisor is 2 to the power min(field, `MAX_EXP`).
- R6: With `HIWORD_MASK = 1`, field bit i takes write-data bit i only when write-data bit 16+i is 1. Otherwise it keeps its value. A write with all mask bits zero changes nothing.
- R7: A written divisor takes effect only at the next terminal count. The period that is running when the write arrives completes at its old length.
- R8: `rd_data_o` returns the stored field in bits 15:0, zero-extended, with bits 31:16 zero. `div_o` is the divisor decoded from the stored field.
- R9: After reset the field is 0 and `tick_o` is low. The first divisor is loaded on the first clock edge after reset is released.
- R10: `tick_o` is a single-cycle pulse. With a valid divisor N, consecutive pulses are exactly N cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data (field in 15:0, mask in 31:16 when enabled) |
| rd_data_o | output | 32 | Read-back of the stored field |
| div_o | output | DIV_W | Divisor decoded from the stored field (0 if invalid) |
| tick_o | output | 1 | One-cycle enable pulse, once per divisor period |
| invalid_o | output | 1 | Loaded divisor is invalid; pulse held off |

## Verification
The bench drives four instances at once, one per encoding variant: plus-one, one-based with mask, one-based with bypass, and power of two. On each it measures the gap between pulses.

- Random field values on the plus-one instance cover the general arithmetic.
- The extremes 0 and 255 expose off-by-one errors and width truncation.
- A power-of-two exponent above the cap confirms the limit is applied.
- A large-to-small divisor change made in mid-period separates deferred loading from immediate loading.
- Masked writes with partial, empty and full masks separate per-bit enabling from whole-field replacement.
- Zero written to the two one-based instances separates the invalid hold from bypass.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    ENC_PLUS_ONE  = 2'd0,
    ENC_ONE_BASED = 2'd1,
    ENC_POW2      = 2'd2
  } div_enc_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/clkdiv_reg.sv
module clkdiv_reg #(
  parameter int unsigned FIELD_W     = 8,
  parameter bit          HIWORD_MASK = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [31:0]        wr_data_i,
  output logic [FIELD_W-1:0] field_o
);
  logic [FIELD_W-1:0] field_q, field_d;
  logic               unused_hi;

  generate
    if (HIWORD_MASK) begin : g_mask
      logic [FIELD_W-1:0] wmask;
      assign wmask   = wr_data_i[16 +: FIELD_W];
      assign field_d = (field_q & ~wmask) | (wr_data_i[FIELD_W-1:0] & wmask);
    end else begin : g_plain
      assign field_d = wr_data_i[FIELD_W-1:0];
    end
  endgenerate

  assign unused_hi = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      field_q <= '0;
    else if (wr_en_i) field_q <= field_d;
  end

  assign field_o = field_q;

  AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(field_q)); // R8

  generate
    if (HIWORD_MASK) begin : g_mask_chk
      AST_MASK_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i[16 +: FIELD_W] == '0) |=> $stable(field_q)); // R6
    end
  endgenerate
endmodule

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import clkdiv_pkg::*;
#(
  parameter int unsigned FIELD_W    = 8,
  parameter int unsigned MAX_EXP    = 12,
  parameter div_enc_e    ENC        = ENC_PLUS_ONE,
  parameter bit          ALLOW_ZERO = 1'b0,
  parameter int unsigned DIV_W      = max_u(FIELD_W + 1, MAX_EXP + 1)
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [DIV_W-1:0]   div_o,
  output logic               inv_o
);
  localparam int unsigned EXP_W = $clog2(MAX_EXP + 1);

  generate
    if (ENC == ENC_POW2) begin : g_pow2
      logic [EXP_W-1:0] exp_c;
      always_comb begin
        if (32'(field_i) > MAX_EXP) exp_c = EXP_W'(MAX_EXP);
        else                        exp_c = EXP_W'(field_i);
      end
      assign div_o = DIV_W'(1) << exp_c;
      assign inv_o = 1'b0;
    end else if (ENC == ENC_ONE_BASED) begin : g_one
      always_comb begin
        if (field_i != '0) begin
          div_o = DIV_W'(field_i);
          inv_o = 1'b0;
        end else if (ALLOW_ZERO) begin
          div_o = DIV_W'(1);   // bypass
          inv_o = 1'b0;
        end else begin
          div_o = '0;
          inv_o = 1'b1;
        end
      end
    end else begin : g_plus
      assign div_o = DIV_W'(field_i) + DIV_W'(1);
      assign inv_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int unsigned DIV_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             inv_i,
  output logic             tick_o,
  output logic             inv_o
);
  logic [DIV_W-1:0] cnt_q, act_div_q;
  logic             act_inv_q, armed_q, load;

  assign tick_o = armed_q && !act_inv_q && (cnt_q == '0);
  // load on first edge, at terminal count, or every cycle while invalid
  assign load   = !armed_q || act_inv_q || (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      act_div_q <= DIV_W'(1);
      act_inv_q <= 1'b0;
      armed_q   <= 1'b0;
    end else if (load) begin
      armed_q   <= 1'b1;
      act_div_q <= div_i;
      act_inv_q <= inv_i;
      cnt_q     <= inv_i ? '0 : div_i - DIV_W'(1);
    end else begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  assign inv_o = act_inv_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !act_inv_q) |-> (cnt_q < act_div_q)); // R10
  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !act_inv_q && cnt_q != '0) |=> $stable(act_div_q)); // R7
  AST_TICK_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (act_inv_q || cnt_q == act_div_q - DIV_W'(1))); // R10
  AST_INV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inv_i) && $past(load) |-> !tick_o); // R3
endmodule

// File: rtl/clkdiv_enc.sv
module clkdiv_enc
  import clkdiv_pkg::*;
#(
  parameter int unsigned FIELD_W     = 8,
  parameter int unsigned MAX_EXP     = 12,
  parameter div_enc_e    ENC         = ENC_PLUS_ONE,
  parameter bit          ALLOW_ZERO  = 1'b0,
  parameter bit          HIWORD_MASK = 1'b0,
  parameter int unsigned DIV_W       = max_u(FIELD_W + 1, MAX_EXP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  output logic [31:0]      rd_data_o,
  output logic [DIV_W-1:0] div_o,
  output logic             tick_o,
  output logic             invalid_o
);
  logic [FIELD_W-1:0] field;
  logic [DIV_W-1:0]   dec_div;
  logic               dec_inv;

  clkdiv_reg #(.FIELD_W(FIELD_W), .HIWORD_MASK(HIWORD_MASK)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .field_o(field)
  );

  clkdiv_decode #(
    .FIELD_W(FIELD_W), .MAX_EXP(MAX_EXP), .ENC(ENC),
    .ALLOW_ZERO(ALLOW_ZERO), .DIV_W(DIV_W)
  ) u_dec (
    .field_i(field), .div_o(dec_div), .inv_o(dec_inv)
  );

  clkdiv_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i, .rst_ni, .div_i(dec_div), .inv_i(dec_inv),
    .tick_o, .inv_o(invalid_o)
  );

  assign rd_data_o = 32'(field);
  assign div_o     = dec_div;

  generate
    if (ENC == ENC_POW2) begin : g_p2_chk
      AST_POW2_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(div_o) == 1); // R5
    end
    if (ENC == ENC_ONE_BASED && ALLOW_ZERO) begin : g_az_chk
      AST_BYPASS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_data_o == 32'd0) |=> !invalid_o); // R4
    end
  endgenerate
endmodule

// File: tb/tb_clkdiv_enc.sv
`timescale 1ns/1ps
module tb_clkdiv_enc;
  import clkdiv_pkg::*;
  localparam int DW = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  wr_en = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd [4];
  logic [DW-1:0] dv [4];
  logic [3:0]  tick, inv;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // 0: plus-one, 1: one-based+mask, 2: one-based bypass, 3: pow2
  clkdiv_enc dut (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en[0]), .wr_data_i(wr_data),
    .rd_data_o(rd[0]), .div_o(dv[0]), .tick_o(tick[0]), .invalid_o(inv[0]));
  clkdiv_enc #(.ENC(ENC_ONE_BASED), .HIWORD_MASK(1'b1)) dut_ob (.clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en[1]), .wr_data_i(wr_data), .rd_data_o(rd[1]), .div_o(dv[1]),
    .tick_o(tick[1]), .invalid_o(inv[1]));
  clkdiv_enc #(.ENC(ENC_ONE_BASED), .ALLOW_ZERO(1'b1)) dut_az (.clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en[2]), .wr_data_i(wr_data), .rd_data_o(rd[2]), .div_o(dv[2]),
    .tick_o(tick[2]), .invalid_o(inv[2]));
  clkdiv_enc #(.ENC(ENC_POW2)) dut_p2 (.clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en[3]), .wr_data_i(wr_data), .rd_data_o(rd[3]), .div_o(dv[3]),
    .tick_o(tick[3]), .invalid_o(inv[3]));

  function automatic int exp_div(int k, int v);
    case (k)
      0: return v + 1;
      1: return v;                       // zero -> invalid (0)
      2: return (v == 0) ? 1 : v;
      default: return 1 << ((v > 12) ? 12 : v);
    endcase
  endfunction

  function automatic int mask_upd(int old, logic [31:0] d);
    return (old & ~int'(d[23:16])) | (int'(d[7:0]) & int'(d[23:16]));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int k, logic [31:0] d);
    @(negedge clk); wr_en[k] = 1'b1; wr_data = d;
    @(negedge clk); wr_en[k] = 1'b0;
  endtask

  task automatic wait_tick(int k);
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (tick[k]) return;
    end
  endtask

  // gap to next tick; call right after a tick was observed
  task automatic gap(int k, output int n);
    n = 0;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk); n++;
      if (tick[k]) return;
    end
  endtask

  task automatic period(int k, output int n);
    wait_tick(k); wait_tick(k); gap(k, n);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, v, f;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R9 reset rd", int'(rd[0]), 0);
    chk("R9 reset tick", int'(tick), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3/R9 invalid after reset", int'(inv[1]), 1);
    chk("R3 div_o zero", int'(dv[1]), 0);
    period(0, n); chk("R9/R1 div1 after reset", n, 1);
    period(2, n); chk("R4 bypass period", n, 1);
    chk("R4 invalid low", int'(inv[2]), 0);
    period(3, n); chk("R5 pow2 exp0", n, 1);

    wr(0, 32'd9);
    chk("R8 rd_data", int'(rd[0]), 9);
    chk("R8 div_o", int'(dv[0]), 10);
    period(0, n); chk("R1/R10 period field 9", n, 10);
    wr(0, 32'hFFFF_00FF);
    chk("R8 upper bits zero", int'(rd[0]), 255);
    period(0, n); chk("R1 period field 255", n, 256);

    // R7: shrink in mid-period
    wr(0, 32'd19); wait_tick(0); wait_tick(0);
    repeat (5) @(negedge clk);
    wr(0, 32'd2);
    gap(0, n); chk("R7 running period kept", n, 20 - 7);
    gap(0, n); chk("R7 new period applied", n, 3);

    for (int i = 0; i < 6; i++) begin
      v = int'($urandom % 40);
      wr(0, 32'(v));
      chk("R8 random rd", int'(rd[0]), v);
      period(0, n); chk("R1 random period", n, exp_div(0, v));
    end

    // masked one-based
    f = 0;
    wr(1, 32'h00FF_0007); f = mask_upd(f, 32'h00FF_0007);
    chk("R6 full mask", int'(rd[1]), f);
    period(1, n); chk("R2 period 7", n, exp_div(1, f));
    chk("R3 invalid cleared", int'(inv[1]), 0);
    wr(1, 32'h0000_0033);
    chk("R6 empty mask ignored", int'(rd[1]), 7);
    wr(1, 32'h000F_00A5); f = mask_upd(f, 32'h000F_00A5);
    chk("R6 partial mask", int'(rd[1]), f);
    period(1, n); chk("R2 period partial", n, 5);
    wr(1, 32'h00FF_0000);
    chk("R3 div_o zero field", int'(dv[1]), 0);
    wait_tick(1); repeat (2) @(negedge clk);
    chk("R3 invalid raised", int'(inv[1]), 1);
    v = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); v += int'(tick[1]); end
    chk("R3 tick held low", v, 0);
    wr(1, 32'h00FF_000C);
    @(negedge clk);
    chk("R3 recover invalid", int'(inv[1]), 0);
    period(1, n); chk("R2 recover period", n, 12);

    wr(2, 32'd4);
    period(2, n); chk("R2 bypass inst period 4", n, 4);
    wr(2, 32'd0);
    chk("R4 div_o one", int'(dv[2]), 1);
    period(2, n); chk("R4 zero bypass", n, 1);
    chk("R4 no invalid", int'(inv[2]), 0);

    wr(3, 32'd3);
    period(3, n); chk("R5 pow2 3", n, exp_div(3, 3));
    wr(3, 32'd7);
    period(3, n); chk("R5 pow2 7", n, exp_div(3, 7));
    wr(3, 32'd200);
    chk("R5 capped div_o", int'(dv[3]), exp_div(3, 200));
    period(3, n); chk("R5 capped period", n, 4096);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule